// File: doc/BRIEF.md
# Stop-Mode Clock and Wake Controller

This controller parks a small processor core and its peripherals in a low-power stop state and brings them back in an orderly way. Software writes a one-byte control register. Setting its top bit removes the clock enables for the CPU and for the peripherals. The controller then waits for an external wake signal. Two control bits pick the wake condition and what the port pins do while the core sleeps. A fourth bit picks the source for a slow timing tick.

Once the wake condition is met, a warm-up counter is loaded from a programmable value and counts down. Clocks come back only when the counter runs out. At that moment a one-cycle interrupt request fires and the stop bit clears itself.

Alongside this, a clock gear turns the fast clock into a gear tick at full rate, half rate or quarter rate. A new ratio takes effect only on a quarter-rate boundary. A stage-9 divider tick is taken either from every second gear tick or from every fourth low-frequency tick. Nothing in the block carries streaming data, so every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `stopwake_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x08, both clock enables are high and `wu_irq` is low.
- R2: While running, a write stores `reg_wdata[6:4]` into control bits 6:4 (bit 6 = level wake, bit 5 = hold outputs, bit 4 = slow-tick source). Bits 3:0 always read 4'b1000, and writes to them have no effect.
- R3: A running write with bit 7 set enters stop on the next cycle: both clock enables go low and read bit 7 is 1. The one exception is in R5.
- R4: With bit 6 clear, stop ends only when `wake_in` is sampled high in a cycle after a cycle in which it was sampled low. A level that stays high does not end stop.
- R5: With bit 6 set, stop ends in any cycle where `wake_in` is high. If `wake_in` is high in the cycle of the write, stop is not entered: bit 7 reads 0 and the clocks stay on.
- R6: When stop ends, the warm-up count L is taken from `wu_load`. The clock enables stay low for L+1 further cycles. They then return high, bit 7 reads 0, and `wu_irq` is high for exactly that first cycle.
- R7: Register writes made while the clocks are gated have no effect.
- R8: While running, `port_oe` and `port_out` follow `port_oe_in` and `port_out_in`. While gated with bit 5 clear, `port_oe` is all zero.
- R9: While gated with bit 5 set, `port_oe` and `port_out` hold the values their inputs had in the cycle of the stop write. Once the clocks return, the outputs follow the inputs again.
- R10: `gear_sel` 0 gives one `gear_tick` per 4 running cycles, 1 gives one per 2, and 2 or 3 gives one every cycle. No `gear_tick` or `div9_tick` appears while gated.
- R11: A new `gear_sel` value takes effect only after the current 4-cycle gear frame ends, so the frame in progress keeps the old ratio.
- R12: With bit 4 clear, `div9_tick` pulses on every second `gear_tick`. With bit 4 set, it pulses on every fourth running cycle with `lf_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-frequency clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| wu_load | input | WU_W | Warm-up count loaded when stop ends |
| wake_in | input | 1 | Stop release signal (synchronous) |
| gear_sel | input | 2 | Gear ratio: 0 quarter, 1 half, 2/3 full |
| lf_tick | input | 1 | One-cycle pulse from the low-frequency clock |
| port_oe_in | input | PORT_W | Port output enables from the core |
| port_out_in | input | PORT_W | Port output values from the core |
| port_oe | output | PORT_W | Port output enables to the pads |
| port_out | output | PORT_W | Port output values to the pads |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| gear_tick | output | 1 | Gear clock enable pulse |
| div9_tick | output | 1 | Stage-9 timing divider input pulse |
| wu_irq | output | 1 | Warm-up done interrupt request, one cycle |

## Verification
The bench builds the block with `WU_W` = 6 and `PORT_W` = 4. The narrow counter keeps every warm-up window short, and it makes a zero load (a single warm-up cycle) easy to drive next to a load of 3. The 4-bit port makes the frozen and the live pin patterns easy to tell apart. The bench covers both wake modes, including a wake level that is already high at entry, a gear change in the middle of a frame, and both slow-tick sources.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2
  } swc_state_e;

  typedef enum logic [1:0] {
    GEAR_DIV4 = 2'd0,
    GEAR_DIV2 = 2'd1,
    GEAR_FULL = 2'd2,
    GEAR_FULL_ALT = 2'd3
  } gear_e;

  typedef struct packed {
    logic stop;
    logic lvl_wake;
    logic hold_out;
    logic slow_src;
  } ctl_t;

  localparam logic [3:0] CTL_LOW_NIBBLE = 4'b1000;
  localparam int GEAR_FRAME_W = 2;
  localparam int LF_DIV_W = 2;
endpackage

// File: rtl/swc_ctrl_fsm.sv
module swc_ctrl_fsm
  import swc_pkg::*;
#(
  parameter int WU_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [3:0]      wr_ctl,
  input  logic            wake_in,
  input  logic [WU_W-1:0] wu_load,
  output ctl_t            ctl,
  output logic            run,
  output logic            wu_irq
);
  swc_state_e      state;
  logic [WU_W-1:0] wu_cnt;
  logic            wake_q;
  logic            release_hit;

  // level mode: any high cycle; edge mode: high now after low before
  assign release_hit = ctl.lvl_wake ? wake_in : (wake_in && !wake_q);
  assign run = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      ctl    <= '0;
      wu_cnt <= '0;
      wake_q <= 1'b0;
      wu_irq <= 1'b0;
    end else begin
      wake_q <= wake_in;
      wu_irq <= 1'b0;
      case (state)
        ST_RUN: begin
          if (reg_wr) begin
            ctl.lvl_wake <= wr_ctl[2];
            ctl.hold_out <= wr_ctl[1];
            ctl.slow_src <= wr_ctl[0];
            // a wake level already present cancels entry in level mode
            if (wr_ctl[3] && !(wr_ctl[2] && wake_in)) begin
              ctl.stop <= 1'b1;
              state    <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (release_hit) begin
            wu_cnt <= wu_load;
            state  <= ST_WARM;
          end
        end
        ST_WARM: begin
          if (wu_cnt == '0) begin
            ctl.stop <= 1'b0;
            wu_irq   <= 1'b1;
            state    <= ST_RUN;
          end else begin
            wu_cnt <= wu_cnt - 1'b1;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/swc_gear.sv
module swc_gear
  import swc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] gear_sel,
  input  logic       slow_src,
  input  logic       lf_tick,
  output logic       gear_tick,
  output logic       div9_tick
);
  localparam logic [GEAR_FRAME_W-1:0] FRAME_LAST = '1;
  localparam logic [LF_DIV_W-1:0]     LF_LAST    = '1;

  logic [GEAR_FRAME_W-1:0] frame;
  logic [LF_DIV_W-1:0]     lf_cnt;
  gear_e                   ratio;
  logic                    half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame  <= '0;
      lf_cnt <= '0;
      ratio  <= GEAR_FULL;
      half   <= 1'b0;
    end else if (run) begin
      frame <= frame + 1'b1;
      // ratio only changes where every ratio has just ended a period
      if (frame == FRAME_LAST) ratio <= gear_e'(gear_sel);
      if (gear_tick) half <= ~half;
      if (lf_tick) lf_cnt <= lf_cnt + 1'b1;
    end
  end

  always_comb begin
    case (ratio)
      GEAR_DIV4: gear_tick = run && (frame == FRAME_LAST);
      GEAR_DIV2: gear_tick = run && frame[0];
      default:   gear_tick = run;
    endcase
    if (slow_src) div9_tick = run && lf_tick && (lf_cnt == LF_LAST);
    else          div9_tick = gear_tick && half;
  end
endmodule

// File: rtl/swc_port_hold.sv
module swc_port_hold #(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              hold_out,
  input  logic [PORT_W-1:0] oe_in,
  input  logic [PORT_W-1:0] out_in,
  output logic [PORT_W-1:0] oe,
  output logic [PORT_W-1:0] out
);
  logic [PORT_W-1:0] oe_frz;
  logic [PORT_W-1:0] out_frz;

  // tracks the pins each running cycle; last update is the entry cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_frz  <= '0;
      out_frz <= '0;
    end else if (run) begin
      oe_frz  <= oe_in;
      out_frz <= out_in;
    end
  end

  always_comb begin
    if (run) begin
      oe  = oe_in;
      out = out_in;
    end else begin
      oe  = hold_out ? oe_frz : '0;
      out = out_frz;
    end
  end
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import swc_pkg::*;
#(
  parameter int WU_W   = 16,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [WU_W-1:0]   wu_load,
  input  logic              wake_in,
  input  logic [1:0]        gear_sel,
  input  logic              lf_tick,
  input  logic [PORT_W-1:0] port_oe_in,
  input  logic [PORT_W-1:0] port_out_in,
  output logic [PORT_W-1:0] port_oe,
  output logic [PORT_W-1:0] port_out,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic              gear_tick,
  output logic              div9_tick,
  output logic              wu_irq
);
  ctl_t ctl;
  logic run;
  logic wdata_unused;

  assign wdata_unused = ^reg_wdata[3:0];

  swc_ctrl_fsm #(.WU_W(WU_W)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .wr_ctl  (reg_wdata[7:4]),
    .wake_in (wake_in),
    .wu_load (wu_load),
    .ctl     (ctl),
    .run     (run),
    .wu_irq  (wu_irq)
  );

  swc_gear u_gear (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .gear_sel  (gear_sel),
    .slow_src  (ctl.slow_src),
    .lf_tick   (lf_tick),
    .gear_tick (gear_tick),
    .div9_tick (div9_tick)
  );

  swc_port_hold #(.PORT_W(PORT_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .hold_out (ctl.hold_out),
    .oe_in    (port_oe_in),
    .out_in   (port_out_in),
    .oe       (port_oe),
    .out      (port_out)
  );

  assign cpu_clk_en    = run;
  assign periph_clk_en = run;
  assign reg_rdata     = {ctl, CTL_LOW_NIBBLE};
endmodule

// File: rtl/swc_chk.sv
module swc_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_clk_en,
  input logic              stop_bit,
  input logic              outen_bit,
  input logic              gear_tick,
  input logic              div9_tick,
  input logic              wu_irq,
  input logic [PORT_W-1:0] port_oe,
  input logic [PORT_W-1:0] port_out
);
  // R10
  gated_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> (!gear_tick && !div9_tick));

  // R6
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wu_irq |=> !wu_irq);

  // R6
  irq_at_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wu_irq |-> (cpu_clk_en && !$past(cpu_clk_en)));

  // R3
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> stop_bit);

  // R8
  highz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !outen_bit) |-> (port_oe == '0));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && !$past(cpu_clk_en) && outen_bit) |-> ($stable(port_oe) && $stable(port_out)));
endmodule

bind stopwake_ctrl swc_chk #(.PORT_W(PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_clk_en (cpu_clk_en),
  .stop_bit   (reg_rdata[7]),
  .outen_bit  (reg_rdata[5]),
  .gear_tick  (gear_tick),
  .div9_tick  (div9_tick),
  .wu_irq     (wu_irq),
  .port_oe    (port_oe),
  .port_out   (port_out)
);

// File: tb/stopwake_ctrl_bench.sv
module stopwake_ctrl_bench;
  localparam int WU_W = 6;
  localparam int PORT_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n, reg_wr, wake_in, lf_tick;
  logic [7:0]        reg_wdata, reg_rdata;
  logic [WU_W-1:0]   wu_load;
  logic [1:0]        gear_sel;
  logic [PORT_W-1:0] port_oe_in, port_out_in, port_oe, port_out;
  logic              cpu_clk_en, periph_clk_en, gear_tick, div9_tick, wu_irq;

  stopwake_ctrl #(.WU_W(WU_W), .PORT_W(PORT_W)) u_stopwake_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wu_load(wu_load), .wake_in(wake_in),
    .gear_sel(gear_sel), .lf_tick(lf_tick), .port_oe_in(port_oe_in),
    .port_out_in(port_out_in), .port_oe(port_oe), .port_out(port_out),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .gear_tick(gear_tick), .div9_tick(div9_tick), .wu_irq(wu_irq)
  );

  typedef struct {
    string tag;
    logic  clk_en;
    logic  irq;
    logic  stop;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one expected item per cycle it was pushed for
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk({e.tag, " cpu_clk_en"}, cpu_clk_en, e.clk_en);
      chk({e.tag, " periph_clk_en"}, periph_clk_en, e.clk_en);
      chk({e.tag, " wu_irq"}, wu_irq, e.irq);
      chk({e.tag, " stop bit"}, reg_rdata[7], e.stop);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(string tag, logic c, logic i, logic s);
    exp_t e;
    e.tag = tag; e.clk_en = c; e.irq = i; e.stop = s;
    q.push_back(e);
  endtask

  task automatic count_ticks(int n, output int g, output int d);
    g = 0; d = 0;
    repeat (n) begin
      @(negedge clk);
      g += int'(gear_tick);
      d += int'(div9_tick);
    end
  endtask

  task automatic write_reg(logic [7:0] v);
    tick(); reg_wr = 1'b1; reg_wdata = v;
    tick(); reg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int g, d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; wake_in = 1'b0; lf_tick = 1'b0;
    wu_load = 6'd3; gear_sel = 2'd2; port_oe_in = '0; port_out_in = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", reg_rdata, 8'h08);
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 periph_clk_en", periph_clk_en, 1);
    chk("R1 wu_irq", wu_irq, 0);

    // R2: bits 6:4 store, low nibble fixed
    write_reg(8'h7F);
    @(negedge clk); chk("R2 rdata after 0x7F", reg_rdata, 8'h78);
    write_reg(8'h00);
    @(negedge clk); chk("R2 rdata after 0x00", reg_rdata, 8'h08);

    // R8 pass-through while running
    tick(); port_oe_in = 4'hA; port_out_in = 4'h5;
    @(negedge clk);
    chk("R8 run oe", port_oe, 4'hA);
    chk("R8 run out", port_out, 4'h5);

    // edge mode, high-Z, wake already high at entry
    tick(); wake_in = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h80; push("R3 write cycle", 1, 0, 0);
    tick(); reg_wr = 1'b0; push("R3 stopped", 0, 0, 1);
    @(negedge clk); chk("R8 highz oe", port_oe, 4'h0);
    tick(); reg_wr = 1'b1; reg_wdata = 8'h10; push("R4 held level no release", 0, 0, 1);
    @(negedge clk); chk("R10 no gear tick while gated", gear_tick, 0);
    tick(); reg_wr = 1'b0; wake_in = 1'b0; push("R4 low", 0, 0, 1);
    tick(); wake_in = 1'b1; push("R4 rising", 0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      tick(); push("R6 warm-up L=3", 0, 0, 1);
    end
    tick(); push("R6 restart", 1, 1, 0);
    tick(); push("R6 after pulse", 1, 0, 0);
    @(negedge clk);
    chk("R7 write while gated ignored", reg_rdata, 8'h08);
    chk("R8 oe restored", port_oe, 4'hA);

    // R5: level mode with wake high at write -> no entry
    tick(); reg_wr = 1'b1; reg_wdata = 8'hC0; push("R5 write with wake high", 1, 0, 0);
    tick(); reg_wr = 1'b0; push("R5 no entry", 1, 0, 0);
    @(negedge clk); chk("R5 rdata", reg_rdata, 8'h48);

    // level mode, hold outputs, zero warm-up load
    tick(); wake_in = 1'b0; wu_load = 6'd0;
    tick(); reg_wr = 1'b1; reg_wdata = 8'hE0; port_oe_in = 4'h6; port_out_in = 4'h9;
    push("R3 level write", 1, 0, 0);
    tick(); reg_wr = 1'b0; port_oe_in = 4'hF; port_out_in = 4'h0; push("R5 stopped", 0, 0, 1);
    @(negedge clk);
    chk("R9 held oe", port_oe, 4'h6);
    chk("R9 held out", port_out, 4'h9);
    tick(); wake_in = 1'b1; push("R5 level release", 0, 0, 1);
    tick(); push("R6 warm-up L=0", 0, 0, 1);
    tick(); wake_in = 1'b0; push("R6 restart L=0", 1, 1, 0);
    @(negedge clk);
    chk("R9 resume oe", port_oe, 4'hF);
    chk("R9 resume out", port_out, 4'h0);

    // R10 gear ratios
    write_reg(8'h00);
    tick(); gear_sel = 2'd0;
    repeat (8) tick();
    count_ticks(8, g, d); chk("R10 quarter rate ticks", g, 2);
    tick(); gear_sel = 2'd1;
    repeat (8) tick();
    count_ticks(8, g, d); chk("R10 half rate ticks", g, 4);
    tick(); gear_sel = 2'd3;
    repeat (8) tick();
    count_ticks(8, g, d);
    chk("R10 full rate ticks", g, 8);
    chk("R12 div9 from gear", d, 4);

    // R12 slow source
    write_reg(8'h10);
    d = 0;
    for (int k = 0; k < 16; k++) begin
      tick(); lf_tick = (k % 2 == 0);
      @(negedge clk); d += int'(div9_tick);
    end
    tick(); lf_tick = 1'b0;
    chk("R12 div9 from lf_tick", d, 2);

    // R11 gear change waits for frame end
    tick(); gear_sel = 2'd0;
    repeat (8) tick();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (gear_tick) break;
    end
    tick(); gear_sel = 2'd2;
    count_ticks(4, g, d); chk("R11 old ratio finishes frame", g, 1);
    count_ticks(4, g, d); chk("R11 new ratio after frame", g, 4);

    repeat (2) @(negedge clk);
    chk("R6 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule